// File: doc/BRIEF.md
# Four-Link Byte-Interleaved Serial Demultiplexer

This block receives one high-rate serial system bus that carries four framed 2 Mbit/s-class links, interleaved one byte at a time. It recovers the position of every incoming bit within the multiplexed frame and returns each completed byte together with the link it belongs to and its timeslot number. Downstream per-link logic uses the strobe, link index and timeslot to steer the byte into the right channel.

Two redundant serial data pins are provided, and a select input picks which one feeds the deserializer. A frame pulse with programmable active level sets the alignment. The pulse may recur at any whole number of frames, and between pulses the position counters run freely and wrap at the frame boundary. The bus can run at the base rate, where every clock carries one bit. It can also run at the double rate, where each bit spans two clocks and is taken on the second clock of the pair.

Top module: `tdm4_byte_demux`

## Requirements
- R1: While rst_n is low, and in the first cycle after release, byte_valid, link_idx, slot_idx and byte_data are all zero.
- R2: Bits are packed most significant bit first: the first bit taken for a byte lands in byte_data[7].
- R3: Successive bytes carry link_idx 0, 1, 2, 3 and then 0 again. Index 0 is the first link in the interleave.
- R4: slot_idx stays constant across one round of four links. It advances by one after the byte with link_idx 3, and it wraps from 31 to 0.
- R5: After the clock edge at which the frame pulse is active, the next bit taken is bit 0 of timeslot 0 of link 0. At the base rate, byte_valid rises after the 8th following edge.
- R6: With fp_active_low = 0 the pulse is active when fp_in is 1. With fp_active_low = 1 it is active when fp_in is 0.
- R7: sel_b = 0 takes data from data_a and sel_b = 1 takes it from data_b. The unselected pin has no effect on byte_data.
- R8: With double_rate = 1, each bit occupies two clocks and is taken on the second. After the frame pulse edge, the first byte appears after the 16th following edge.
- R9: An active frame pulse discards any partly assembled byte. byte_valid is 0 in the cycle that follows the pulse edge.
- R10: Without a frame pulse, the counters wrap after 1024 bits (32 slots x 4 links x 8 bits) and continue with link 0, slot 0.
- R11: byte_valid is high for exactly one cycle per completed byte. It is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Multiplexed bus clock; all sampling on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| data_a | input | 1 | Serial data, pin A |
| data_b | input | 1 | Serial data, pin B |
| sel_b | input | 1 | 1 selects data_b, 0 selects data_a |
| fp_in | input | 1 | Frame start pulse |
| fp_active_low | input | 1 | 1 makes fp_in active low |
| double_rate | input | 1 | 1 when each bit spans two clocks |
| byte_valid | output | 1 | One-cycle strobe for a completed byte |
| link_idx | output | 2 | Link of the presented byte |
| slot_idx | output | 5 | Timeslot of the presented byte |
| byte_data | output | 8 | Assembled byte, MSB first on the wire |

## Verification
A position counter that slips by one bit shows up within one byte as a rotated byte_data. A wrong link or slot counter shows up as an out-of-order link_idx or slot_idx on the next strobe. A wrong phase in double-rate mode shows up at the first strobe after a pulse, as a byte arriving on the wrong edge and built from the wrong half of each bit period. The bench drives independent random values on both data pins every clock and compares every cycle against a reference model of the frame position. Any such fault is therefore caught within one byte time of the mistake.

// File: rtl/tdmx_pkg.sv
package tdmx_pkg;

  // Advance a counter that wraps after reaching last.
  function automatic int step_wrap(int cur, int last);
    return (cur >= last) ? 0 : cur + 1;
  endfunction

  // Resolve the programmable active level of the frame pulse.
  function automatic logic pulse_active(logic raw, logic active_low);
    return raw ^ active_low;
  endfunction

  // Pick one of the two redundant serial pins.
  function automatic logic pick_pin(logic pin_a, logic pin_b, logic use_b);
    return use_b ? pin_b : pin_a;
  endfunction

endpackage

// File: rtl/tdmx_bit_timer.sv
module tdmx_bit_timer (
  input  logic clk,
  input  logic rst_n,
  input  logic double_rate,
  input  logic frame_hit,
  output logic sample_en
);
  // phase = 1 marks the second clock of a bit pair in double-rate mode
  logic phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
    end else if (frame_hit) begin
      phase_q <= 1'b0;
    end else if (double_rate) begin
      phase_q <= ~phase_q;
    end else begin
      phase_q <= 1'b0;
    end
  end

  assign sample_en = !double_rate || phase_q;
endmodule

// File: rtl/tdmx_pos_counter.sv
module tdmx_pos_counter #(
  parameter int N_LINKS = 4,
  parameter int N_SLOTS = 32,
  parameter int BYTE_W  = 8,
  parameter int LINK_W  = $clog2(N_LINKS),
  parameter int SLOT_W  = $clog2(N_SLOTS),
  parameter int BIT_W   = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_hit,
  input  logic              sample_en,
  output logic [LINK_W-1:0] link_cur,
  output logic [SLOT_W-1:0] slot_cur,
  output logic              byte_done
);
  import tdmx_pkg::*;

  logic [BIT_W-1:0] bit_q;
  logic             last_bit;
  logic             last_link;
  logic             advance;

  assign advance   = sample_en && !frame_hit;
  assign last_bit  = (int'(bit_q) == BYTE_W - 1);
  assign last_link = (int'(link_cur) == N_LINKS - 1);
  assign byte_done = advance && last_bit;

  always_ff @(posedge clk) begin
    if (!rst_n || frame_hit) begin
      bit_q    <= '0;
      link_cur <= '0;
      slot_cur <= '0;
    end else if (advance) begin
      bit_q <= BIT_W'(step_wrap(int'(bit_q), BYTE_W - 1));
      if (last_bit) begin
        link_cur <= LINK_W'(step_wrap(int'(link_cur), N_LINKS - 1));
        if (last_link) begin
          slot_cur <= SLOT_W'(step_wrap(int'(slot_cur), N_SLOTS - 1));
        end
      end
    end
  end
endmodule

// File: rtl/tdmx_shifter.sv
module tdmx_shifter #(
  parameter int BYTE_W = 8,
  parameter int LINK_W = 2,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_hit,
  input  logic              sample_en,
  input  logic              din,
  input  logic              byte_done,
  input  logic [LINK_W-1:0] link_cur,
  input  logic [SLOT_W-1:0] slot_cur,
  output logic              byte_valid,
  output logic [LINK_W-1:0] link_idx,
  output logic [SLOT_W-1:0] slot_idx,
  output logic [BYTE_W-1:0] byte_data
);
  // Holds the first BYTE_W-1 bits of the byte being assembled.
  logic [BYTE_W-2:0] shreg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg_q    <= '0;
      byte_valid <= 1'b0;
      link_idx   <= '0;
      slot_idx   <= '0;
      byte_data  <= '0;
    end else if (frame_hit) begin
      shreg_q    <= '0;
      byte_valid <= 1'b0;
    end else if (sample_en) begin
      shreg_q    <= {shreg_q[BYTE_W-3:0], din};
      byte_valid <= byte_done;
      if (byte_done) begin
        byte_data <= {shreg_q, din};
        link_idx  <= link_cur;
        slot_idx  <= slot_cur;
      end
    end else begin
      byte_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tdm4_byte_demux.sv
module tdm4_byte_demux #(
  parameter int N_LINKS = 4,
  parameter int N_SLOTS = 32,
  parameter int BYTE_W  = 8,
  parameter int LINK_W  = $clog2(N_LINKS),
  parameter int SLOT_W  = $clog2(N_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_a,
  input  logic              data_b,
  input  logic              sel_b,
  input  logic              fp_in,
  input  logic              fp_active_low,
  input  logic              double_rate,
  output logic              byte_valid,
  output logic [LINK_W-1:0] link_idx,
  output logic [SLOT_W-1:0] slot_idx,
  output logic [BYTE_W-1:0] byte_data
);
  import tdmx_pkg::*;

  // Named internal events, also observed by the checker
  logic              frame_hit;
  logic              sample_en;
  logic              byte_done;
  logic              din_sel;
  logic [LINK_W-1:0] link_cur;
  logic [SLOT_W-1:0] slot_cur;

  assign frame_hit = pulse_active(fp_in, fp_active_low);
  assign din_sel   = pick_pin(data_a, data_b, sel_b);

  tdmx_bit_timer u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .double_rate (double_rate),
    .frame_hit   (frame_hit),
    .sample_en   (sample_en)
  );

  tdmx_pos_counter #(
    .N_LINKS (N_LINKS),
    .N_SLOTS (N_SLOTS),
    .BYTE_W  (BYTE_W),
    .LINK_W  (LINK_W),
    .SLOT_W  (SLOT_W)
  ) u_pos (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_hit (frame_hit),
    .sample_en (sample_en),
    .link_cur  (link_cur),
    .slot_cur  (slot_cur),
    .byte_done (byte_done)
  );

  tdmx_shifter #(
    .BYTE_W (BYTE_W),
    .LINK_W (LINK_W),
    .SLOT_W (SLOT_W)
  ) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_hit  (frame_hit),
    .sample_en  (sample_en),
    .din        (din_sel),
    .byte_done  (byte_done),
    .link_cur   (link_cur),
    .slot_cur   (slot_cur),
    .byte_valid (byte_valid),
    .link_idx   (link_idx),
    .slot_idx   (slot_idx),
    .byte_data  (byte_data)
  );
endmodule

// File: rtl/tdmx_checker.sv
module tdmx_checker #(
  parameter int N_LINKS = 4,
  parameter int N_SLOTS = 32,
  parameter int LINK_W  = 2,
  parameter int SLOT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_hit,
  input logic              sample_en,
  input logic              double_rate,
  input logic              byte_valid,
  input logic [LINK_W-1:0] link_idx,
  input logic [SLOT_W-1:0] slot_idx
);
  logic              since_frame;
  logic              have_prev;
  logic [LINK_W-1:0] last_link;
  logic [SLOT_W-1:0] last_slot;

  function automatic logic [LINK_W-1:0] link_after(logic [LINK_W-1:0] v);
    return (int'(v) == N_LINKS - 1) ? '0 : v + LINK_W'(1);
  endfunction

  function automatic logic [SLOT_W-1:0] slot_after(logic [LINK_W-1:0] l, logic [SLOT_W-1:0] s);
    if (int'(l) != N_LINKS - 1) return s;
    return (int'(s) == N_SLOTS - 1) ? '0 : s + SLOT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_frame <= 1'b1;
      have_prev   <= 1'b0;
      last_link   <= '0;
      last_slot   <= '0;
    end else begin
      if (frame_hit)       since_frame <= 1'b1;
      else if (byte_valid) since_frame <= 1'b0;
      if (byte_valid) begin
        have_prev <= 1'b1;
        last_link <= link_idx;
        last_slot <= slot_idx;
      end
    end
  end

  p_link_sequence_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && have_prev && !since_frame) |-> link_idx == link_after(last_link));

  p_slot_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && have_prev && !since_frame) |-> slot_idx == slot_after(last_link, last_slot));

  p_origin_after_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && since_frame) |-> (link_idx == '0 && slot_idx == '0));

  p_half_rate_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && double_rate) |=> (!sample_en || !double_rate));

  p_pulse_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_hit |=> !byte_valid);

  p_single_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);
endmodule

bind tdm4_byte_demux tdmx_checker #(
  .N_LINKS (N_LINKS),
  .N_SLOTS (N_SLOTS),
  .LINK_W  (LINK_W),
  .SLOT_W  (SLOT_W)
) u_chk (.*);

// File: tb/tb_tdm4_byte_demux.sv
module tb_tdm4_byte_demux;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME_BITS = 1024;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rst_n, data_a, data_b, sel_b, fp_in, fp_active_low, double_rate;
  logic       byte_valid;
  logic [1:0] link_idx;
  logic [4:0] slot_idx;
  logic [7:0] byte_data;

  tdm4_byte_demux dut (
    .clk(clk), .rst_n(rst_n), .data_a(data_a), .data_b(data_b), .sel_b(sel_b),
    .fp_in(fp_in), .fp_active_low(fp_active_low), .double_rate(double_rate),
    .byte_valid(byte_valid), .link_idx(link_idx), .slot_idx(slot_idx), .byte_data(byte_data)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Reference position: absolute bit offset into the frame
  int         m_off;
  bit         m_half;
  logic [7:0] m_acc;
  bit         m_valid;
  int         m_link, m_slot;
  logic [7:0] m_data;
  bit         prev_valid;
  int         seed_dummy;

  function automatic int link_of(int off);
    return (off / 8) % 4;
  endfunction

  function automatic int slot_of(int off);
    return (off / 32) % 32;
  endfunction

  task automatic fail(string tag, string what, int act, int exp);
    errors++;
    $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
  endtask

  task automatic model_reset();
    m_off = 0; m_half = 0; m_acc = '0; m_valid = 0; prev_valid = 0;
  endtask

  task automatic model_edge(bit pulse, logic d);
    bit take;
    m_valid = 0;
    if (pulse) begin
      m_off = 0; m_half = 0;
    end else begin
      take = !double_rate || m_half;
      m_half = double_rate ? !m_half : 1'b0;
      if (take) begin
        m_acc = {m_acc[6:0], d};
        if (m_off % 8 == 7) begin
          m_valid = 1; m_data = m_acc;
          m_link = link_of(m_off); m_slot = slot_of(m_off);
        end
        m_off = (m_off + 1) % FRAME_BITS;
      end
    end
  endtask

  task automatic cyc_d(bit pulse, logic da, logic db, string tag);
    data_a = da; data_b = db;
    fp_in  = pulse ^ fp_active_low;
    @(posedge clk);
    model_edge(pulse, sel_b ? db : da);
    @(negedge clk);
    checks++;
    if (byte_valid !== m_valid) fail(tag, "byte_valid", int'(byte_valid), int'(m_valid));
    else if (m_valid) begin
      if (int'(link_idx) != m_link) fail(tag, "link_idx", int'(link_idx), m_link);
      if (int'(slot_idx) != m_slot) fail(tag, "slot_idx", int'(slot_idx), m_slot);
      if (byte_data !== m_data)     fail(tag, "byte_data", int'(byte_data), int'(m_data));
    end
    if (byte_valid && prev_valid) begin
      checks++;
      fail("R11", "back-to-back strobe", 1, 0);
    end
    prev_valid = byte_valid;
  endtask

  task automatic cyc(bit pulse, string tag);
    cyc_d(pulse, 1'($urandom), 1'($urandom), tag);
  endtask

  task automatic first_valid_after_pulse(int expect_n, string tag);
    int seen;
    seen = -1;
    cyc(1, tag);
    for (int i = 1; i <= expect_n + 4; i++) begin
      cyc(0, tag);
      if (byte_valid && seen < 0) seen = i;
    end
    checks++;
    if (seen != expect_n) fail(tag, "edges to first byte", seen, expect_n);
  endtask

  task automatic send_byte(logic [7:0] b, bit on_b, string tag);
    for (int i = 7; i >= 0; i--) begin
      if (on_b) cyc_d(0, ~b[i], b[i], tag);
      else      cyc_d(0, b[i], ~b[i], tag);
    end
  endtask

  initial begin
    seed_dummy = $urandom(32'd4242);
    rst_n = 0; data_a = 0; data_b = 0; sel_b = 0; fp_in = 0;
    fp_active_low = 0; double_rate = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (byte_valid !== 1'b0 || link_idx !== '0 || slot_idx !== '0 || byte_data !== '0)
      fail("R1", "outputs in reset", int'({byte_valid, link_idx, slot_idx, byte_data}), 0);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (byte_valid !== 1'b0) fail("R1", "byte_valid after release", int'(byte_valid), 0);
    model_reset();

    // R5: base-rate latency from pulse to first byte
    first_valid_after_pulse(8, "R5");

    // R2: directed MSB-first byte
    cyc(1, "R2");
    send_byte(8'hA5, 0, "R2");
    checks++;
    if (byte_data !== 8'hA5) fail("R2", "msb-first byte", int'(byte_data), 8'hA5);

    // R3 R4 R10: free-running over two full frames
    cyc(1, "R3");
    for (int i = 0; i < 2 * FRAME_BITS + 40; i++) cyc(0, "R3 R4 R10");

    // R7: pin B selected, pin A carries the complement
    sel_b = 1;
    cyc(1, "R7");
    send_byte(8'h3C, 1, "R7");
    checks++;
    if (byte_data !== 8'h3C) fail("R7", "pin B byte", int'(byte_data), 8'h3C);
    for (int i = 0; i < 600; i++) cyc(0, "R7");
    sel_b = 0;

    // R6: active-low frame pulse, re-aligning mid frame
    fp_active_low = 1;
    for (int i = 0; i < 37; i++) cyc(0, "R6");
    first_valid_after_pulse(8, "R6");
    for (int i = 0; i < 500; i++) cyc(($urandom % 300) == 0, "R6");
    fp_active_low = 0;

    // R8: double rate, bit taken on the second clock
    double_rate = 1;
    first_valid_after_pulse(16, "R8");
    for (int i = 0; i < 2 * FRAME_BITS + 100; i++) cyc(0, "R8 R10");
    double_rate = 0;

    // R9: pulse in mid byte and exactly on the eighth bit
    cyc(1, "R9");
    for (int i = 0; i < 5; i++) cyc(0, "R9");
    cyc(1, "R9");
    for (int i = 0; i < 7; i++) cyc(0, "R9");
    cyc(1, "R9");
    checks++;
    if (byte_valid !== 1'b0) fail("R9", "strobe after pulse on last bit", int'(byte_valid), 0);
    for (int i = 0; i < 200; i++) cyc(($urandom % 23) == 0, "R9 R11");

    // Mixed random tail
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 500) == 0) double_rate = ~double_rate;
      cyc(($urandom % 700) == 0 || (i == 0), "R3 R8 R11");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule